// File: doc/BRIEF.md
# Bus Trace Entry Formatter

This block turns sampled system-bus transactions into 128-bit words for a trace memory. Each cycle it sees the address-phase fields of the bus (byte enables, cacheability, command, line address, transaction ID) and the 256-bit data bus. It also sees two capture strobes from an upstream trigger sequencer: one that asks for the address phase only, and one that also asks for the data. An accepted strobe produces one control entry. That entry packs the bus fields, a compressed per-doubleword valid mask, the number of idle bus cycles since the previous control entry, and flags telling which strobe caused the capture.

If the data strobe took part in the capture, the data bus is latched in that same cycle. It is then written as two more entries on the next two cycles, upper half first. While those data entries are still pending the block raises a busy output and drops any new strobe. The trace memory only needs to take a word into its next slot whenever the write enable is high.

Top module: `bus_trace_fmt`

## Requirements
- R1: After reset the write enable and the busy output are low, and the gap counter starts from zero. A capture on the first clock edge after reset release reports a count of 0.
- R2: A control entry holds the raw byte enables in bits 31:0, zeros in bits 59:32, cacheability in 65:64, command in 68:66, line address bits 39:5 in 103:69 and the transaction ID in 113:104. Cacheability codes are 00 cacheable non-coherent, 01 cacheable coherent, 10 uncacheable and 11 uncacheable accelerated. Command codes are 000 shared read, 001 exclusive read, 010 write, 011 write-and-invalidate, 100 invalidate, 101/110 reserved and 111 no command. Both fields are copied unchanged.
- R3: Bits 63:60 of a control entry form a mask. Bit n (n = 0..3) is the OR of byte enables 8n through 8n+7.
- R4: Bits 125:114 of a control entry count the clock cycles between the previous control entry and this one. Control entries on two consecutive cycles give 0.
- R5: The count in bits 125:114 saturates at 4095 and does not wrap.
- R6: A capture caused by the address strobe alone sets bit 127, clears bit 126, and writes exactly one entry. Busy stays low.
- R7: A capture that includes the data strobe sets bit 126. On the next two cycles it writes the data bus value from the strobe cycle: first bits 255:128, then bits 127:0.
- R8: When both strobes are high in the same accepted cycle, one control entry has bits 127 and 126 both set, and the two data entries follow it.
- R9: Busy is high on the cycles where the control entry and the upper data entry are presented. A strobe in such a cycle is ignored, and a strobe in the cycle that presents the lower data entry is accepted.
- R10: Data entries do not clear the gap counter. It keeps counting through them, so a control entry written after a data capture includes those cycles in its count.
- R11: The write enable is high only in the cycle after an accepted strobe or while a data entry is being presented. With no strobe and nothing pending, nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| be_i | input | 32 | Byte enables of the address phase |
| cache_i | input | 2 | Cacheability code |
| cmd_i | input | 3 | Command code |
| line_addr_i | input | 35 | Line address, bus address bits 39:5 |
| txn_id_i | input | 10 | Transaction ID (requester and sequence number) |
| data_i | input | 256 | Data bus |
| addr_smp_i | input | 1 | Capture strobe for the address phase only |
| data_smp_i | input | 1 | Capture strobe for the address phase plus data |
| busy_o | output | 1 | Data entries pending; strobes are dropped |
| trace_we_o | output | 1 | Trace memory write enable |
| trace_word_o | output | 128 | Trace memory write word |

## Verification
The bench builds the block with its default parameters: 32 byte enables in four doubleword groups, a 256-bit data bus split into two 128-bit halves, and a 12-bit gap counter. These are the widths the entry layout fixes. Because the counter keeps its full 12 bits, the bench reaches the saturation point at 4095 directly, with a run of more than 4095 idle cycles. Random strobe patterns land strobes on every phase of the data sequence, including the two busy cycles and the first free cycle after them. They also produce back-to-back captures, which give a count of zero.

// File: rtl/trace_fmt_pkg.sv
package trace_fmt_pkg;
  localparam int unsigned BE_W    = 32;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned DW_N    = BE_W / LANE_W;
  localparam int unsigned DATA_W  = 256;
  localparam int unsigned ENTRY_W = 128;
  localparam int unsigned GAP_W   = 12;
  localparam int unsigned ADDR_W  = 35;
  localparam int unsigned ID_W    = 10;
  localparam int unsigned PAD_W   = ENTRY_W - 2 - GAP_W - ID_W - ADDR_W - 3 - 2 - DW_N - BE_W;

  typedef struct packed {
    logic              atrig;
    logic              dtrig;
    logic [GAP_W-1:0]  gap;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        cmd;
    logic [1:0]        cache;
    logic [DW_N-1:0]   dw_mask;
    logic [PAD_W-1:0]  pad;
    logic [BE_W-1:0]   be;
  } ctrl_entry_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HI   = 2'd1,
    SEQ_LO   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/be_mask_reduce.sv
module be_mask_reduce #(
  parameter int unsigned BE_W   = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW_N  = BE_W / LANE_W
) (
  input  logic [BE_W-1:0] be_i,
  output logic [DW_N-1:0] mask_o
);
  for (genvar g = 0; g < DW_N; g++) begin : g_dw
    assign mask_o[g] = |be_i[g*LANE_W +: LANE_W];
  end

  always_comb begin
    AST_MASK_EMPTY: assert (|be_i || mask_o == '0); // R3
  end
endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (cnt_o != CntMax)  cnt_o <= cnt_o + 1'b1;
  end

  AST_GAP_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CntMax && !clr_i) |=> cnt_o == CntMax); // R5
  AST_GAP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R4
endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import trace_fmt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_smp_i,
  input  logic data_smp_i,
  output logic accept_o,
  output logic emit_hi_o,
  output logic emit_lo_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;

  assign accept_o  = (state_q == SEQ_IDLE) && (addr_smp_i || data_smp_i);
  assign emit_hi_o = (state_q == SEQ_HI);
  assign emit_lo_o = (state_q == SEQ_LO);
  assign busy_o    = (state_q != SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept_o && data_smp_i) state_d = SEQ_HI;
      SEQ_HI:   state_d = SEQ_LO;
      SEQ_LO:   state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  AST_HI_THEN_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_hi_o |=> emit_lo_o); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (addr_smp_i || data_smp_i)) |-> !accept_o); // R9
endmodule

// File: rtl/bus_trace_fmt.sv
module bus_trace_fmt
  import trace_fmt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BE_W-1:0]      be_i,
  input  logic [1:0]           cache_i,
  input  logic [2:0]           cmd_i,
  input  logic [ADDR_W-1:0]    line_addr_i,
  input  logic [ID_W-1:0]      txn_id_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 addr_smp_i,
  input  logic                 data_smp_i,
  output logic                 busy_o,
  output logic                 trace_we_o,
  output logic [ENTRY_W-1:0]   trace_word_o
);
  localparam int unsigned HalfW = DATA_W / 2;

  logic              accept, emit_hi, emit_lo;
  logic [DW_N-1:0]   dw_mask;
  logic [GAP_W-1:0]  gap_cnt;
  logic [DATA_W-1:0] data_q;
  ctrl_entry_t       ctrl;

  be_mask_reduce #(.BE_W(BE_W), .LANE_W(LANE_W)) u_mask (
    .be_i   (be_i),
    .mask_o (dw_mask)
  );

  gap_counter #(.CNT_W(GAP_W)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .cnt_o  (gap_cnt)
  );

  entry_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_smp_i (addr_smp_i),
    .data_smp_i (data_smp_i),
    .accept_o   (accept),
    .emit_hi_o  (emit_hi),
    .emit_lo_o  (emit_lo),
    .busy_o     (busy_o)
  );

  always_comb begin
    ctrl         = '0;
    ctrl.atrig   = addr_smp_i;
    ctrl.dtrig   = data_smp_i;
    ctrl.gap     = gap_cnt;
    ctrl.id      = txn_id_i;
    ctrl.addr    = line_addr_i;
    ctrl.cmd     = cmd_i;
    ctrl.cache   = cache_i;
    ctrl.dw_mask = dw_mask;
    ctrl.be      = be_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   data_q <= '0;
    else if (accept && data_smp_i) data_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trace_we_o   <= 1'b0;
      trace_word_o <= '0;
    end else begin
      trace_we_o <= accept | emit_hi | emit_lo;
      if (accept)       trace_word_o <= ctrl;
      else if (emit_hi) trace_word_o <= data_q[DATA_W-1:HalfW];
      else if (emit_lo) trace_word_o <= data_q[HalfW-1:0];
    end
  end

  AST_CTRL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> trace_we_o && trace_word_o[125:114] == $past(gap_cnt)); // R4
  AST_DATA_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && data_smp_i) |=> busy_o); // R7
  AST_ADDR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && addr_smp_i && !data_smp_i) |=> !busy_o); // R6
  AST_BUSY_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> trace_we_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !addr_smp_i && !data_smp_i) |=> !trace_we_o); // R11
endmodule

// File: tb/bus_trace_fmt_tb_top.sv
module bus_trace_fmt_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  be = '0;
  logic [1:0]   cache = '0;
  logic [2:0]   cmd = 3'b111;
  logic [34:0]  laddr = '0;
  logic [9:0]   tid = '0;
  logic [255:0] data = '0;
  logic         as = 1'b0, ds = 1'b0;
  logic         busy, we;
  logic [127:0] word;

  int unsigned vectors = 0, miscompares = 0, cyc = 0;
  logic         done = 1'b0;

  // reference model state
  int           m_pend = 0;
  int           m_gap = 0;
  logic [255:0] m_data = '0;
  bit           m_after_data = 0;
  // expectations for the next presented cycle
  bit           e_we = 0, e_busy = 0, e_ctrl = 0, e_after = 0;
  logic [127:0] e_word = '0;
  string        e_tag = "R11";

  always #5 clk = ~clk;

  bus_trace_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .be_i(be), .cache_i(cache), .cmd_i(cmd),
    .line_addr_i(laddr), .txn_id_i(tid), .data_i(data),
    .addr_smp_i(as), .data_smp_i(ds),
    .busy_o(busy), .trace_we_o(we), .trace_word_o(word)
  );

  function automatic logic [3:0] exp_mask(logic [31:0] b);
    logic [3:0] m = '0;
    for (int n = 0; n < 4; n++)
      for (int k = 0; k < 8; k++) m[n] = m[n] | b[8*n + k];
    return m;
  endfunction

  function automatic logic [127:0] exp_ctrl(logic a, logic d, int gap);
    logic [127:0] w = '0;
    w[31:0]    = be;
    w[63:60]   = exp_mask(be);
    w[65:64]   = cache;
    w[68:66]   = cmd;
    w[103:69]  = laddr;
    w[113:104] = tid;
    w[125:114] = 12'(gap);
    w[126]     = d;
    w[127]     = a;
    return w;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive current inputs, advance model, then check presented outputs
  task automatic step();
    bit acc;
    acc = (m_pend == 0) && (as || ds);
    e_after = m_after_data;
    if (acc) begin
      e_we = 1; e_ctrl = 1;
      e_word = exp_ctrl(as, ds, m_gap);
      e_tag = (as && ds) ? "R8" : (ds ? "R7" : "R6");
      m_gap = 0; m_after_data = 0;
      if (ds) begin m_data = data; m_pend = 2; m_after_data = 1; end
    end else begin
      if (m_pend == 2) begin e_we = 1; e_ctrl = 0; e_word = m_data[255:128]; m_pend = 1; e_tag = "R7"; end
      else if (m_pend == 1) begin e_we = 1; e_ctrl = 0; e_word = m_data[127:0]; m_pend = 0; e_tag = "R7"; end
      else begin e_we = 0; e_ctrl = 0; e_tag = "R11"; end
      if (m_gap < 4095) m_gap++;
    end
    e_busy = (m_pend != 0);
    @(negedge clk);
    chk(e_tag, 128'(we), 128'(e_we));
    chk("R9", 128'(busy), 128'(e_busy));
    if (e_we && we) begin
      if (e_ctrl) begin
        chk("R2", {word[113:64], word[59:0]}, {e_word[113:64], e_word[59:0]});
        chk("R3", 128'(word[63:60]), 128'(e_word[63:60]));
        chk(e_word[125:114] == 12'hFFF ? "R5" : (e_after ? "R10" : "R4"),
            128'(word[125:114]), 128'(e_word[125:114]));
        chk(e_tag, 128'(word[127:126]), 128'(e_word[127:126]));
      end else begin
        chk(e_tag, word, e_word);
      end
    end
  endtask

  task automatic rand_fields();
    case ($urandom_range(0, 3))
      0: be = '0;
      1: be = 32'hFF << (8 * $urandom_range(0, 3));
      2: be = 32'(1) << $urandom_range(0, 31);
      default: be = $urandom;
    endcase
    cache = 2'($urandom); cmd = 3'($urandom);
    laddr = {3'($urandom), $urandom}; tid = 10'($urandom);
    for (int i = 0; i < 8; i++) data[32*i +: 32] = $urandom;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin as = 0; ds = 0; rand_fields(); step(); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      miscompares++;
      $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0125);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 128'(we), 128'(0));
    chk("R1", 128'(busy), 128'(0));
    rst_n = 1'b1;
    // R1: capture at the first edge reports zero
    rand_fields(); as = 1; ds = 0; step();
    // R4: back-to-back captures
    rand_fields(); as = 1; step();
    rand_fields(); as = 1; step();
    // R3: one group per capture
    for (int g = 0; g < 4; g++) begin
      rand_fields(); be = 32'h01 << (8 * g + g); as = 1; ds = 0; step();
    end
    // R7/R9/R10: data capture, strobes held during busy, then free cycle
    rand_fields(); as = 0; ds = 1; step();
    rand_fields(); as = 1; ds = 1; step();
    rand_fields(); as = 1; ds = 1; step();
    rand_fields(); as = 1; ds = 0; step();
    idle(3);
    // R8: both strobes together
    rand_fields(); as = 1; ds = 1; step();
    idle(2);
    rand_fields(); as = 1; ds = 0; step();
    // R5: saturation
    idle(4200);
    rand_fields(); as = 1; ds = 0; step();
    rand_fields(); as = 1; step();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      rand_fields();
      as = ($urandom_range(0, 2) == 0);
      ds = ($urandom_range(0, 3) == 0);
      step();
    end
    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule